// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the clocked control logic that sits between a PWM controller and the two gate drivers of a synchronous buck half-bridge. An external window comparator has already sorted the PWM pin into one of three classes: driven low, driven high, or floating at mid-level. The block turns that class, a supply-good flag and an enable into high-side and low-side gate commands. It holds both switches off while the stage is disabled or the supply is in lockout. It turns both off when the PWM pin floats for longer than a hold-off time. It also keeps both off after every start until the controller sends one high pulse that is long enough, so that a pre-charged output is not pulled down by the low-side switch.

Each gate may turn on only when the opposite switch reports, through an off-feedback input, that it is off, and only after a programmable dead time has run out. All time constants are parameters counted in clock cycles. The supply flag and the enable are taken as synchronous to the clock. The PWM class passes through a two-flop synchronizer before any timing is applied to it.

Top module: `gdrv_seq`

## Requirements
- R1: From the first clock edge at which `en` is sampled low, both gate outputs are low and `mode` reads 1 (disabled), whatever `pwm_cls` is.
- R2: From the first clock edge at which `supply_ok` is sampled low, both gate outputs are low and `mode` reads 0 (lockout). Lockout takes priority over disabled.
- R3: `pwm_cls` is encoded 00 = low, 01 = high, 10 or 11 = mid. In switching, a change of class to high turns the low side off at the 4th clock edge after the change (two synchronizer edges, one classifier edge, one gate edge) and then turns the high side on. A change of class to low does the mirror image.
- R4: A mid class that lasts more than HOLD_CYC cycles turns both gates off at the (4+HOLD_CYC)th edge and sets `mode` to 4 (tri-state off). A mid class of HOLD_CYC cycles or fewer keeps the previous gate state. Leaving tri-state off to a driven class turns the matching gate on at the 4th edge.
- R5: After reset, and after any return from lockout or disabled, `mode` reads 2 (pre-bias wait) and both gates stay low, even while the class is low.
- R6: In pre-bias wait, a high class that lasts at least MINON_CYC cycles releases the guard. `mode` reads 3 at the (3+MINON_CYC)th edge after the class rose. A shorter high pulse leaves `mode` at 2 and both gates low.
- R7: The guard is released only once. Later high pulses shorter than MINON_CYC switch the gates normally. The guard re-arms only through disable or lockout.
- R8: The high-side and low-side gate outputs are never high in the same cycle.
- R9: A gate turns on only at an edge at which the opposite switch's off-feedback is high. While that feedback stays low, the requested gate stays off.
- R10: Between one gate turning off and the other turning on, both gates are low for at least DEAD_CYC cycles (exactly DEAD_CYC when the feedback is prompt).
- R11: `mode` encodes 0 = lockout, 1 = disabled, 2 = pre-bias wait, 3 = switching, 4 = tri-state off; no other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| supply_ok | input | 1 | Gate-drive supply above lockout (hysteresis applied outside) |
| en | input | 1 | Stage enable, high to run |
| pwm_cls | input | 2 | Classified PWM level: 00 low, 01 high, 10/11 mid |
| hs_off_fb | input | 1 | High when the high-side switch is confirmed off |
| ls_off_fb | input | 1 | High when the low-side switch is confirmed off |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |
| mode | output | 3 | Current operating mode (see R11) |

## Verification
Every result has a fixed latency counted in clock edges from the falling edge where the bench changes an input. Enable and supply results are due at the 1st edge. A gate turn-off from a class change is due at the 4th edge and the opposite turn-on at the (4+DEAD_CYC)th. The guard release shows in `mode` at the (3+MINON_CYC)th edge after the rise, and the tri-state timeout at the (4+HOLD_CYC)th. The directed tasks advance an exact number of rising edges and sample on the following falling edge. For each timing edge they check the state one edge before the deadline and again on the deadline itself, and the pulse-length cases sit exactly at and one cycle below each threshold.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

  typedef enum logic [1:0] {
    PC_LOW  = 2'b00,
    PC_HIGH = 2'b01,
    PC_MID  = 2'b10
  } pwm_cls_e;

  typedef enum logic [2:0] {
    MD_LOCKOUT  = 3'd0,
    MD_DISABLED = 3'd1,
    MD_PREBIAS  = 3'd2,
    MD_SWITCH   = 3'd3,
    MD_TRIOFF   = 3'd4
  } mode_e;

  // raw comparator code to class; code 11 folds into mid
  function automatic pwm_cls_e decode_cls(input logic [1:0] raw);
    pwm_cls_e c;
    case (raw)
      2'b00:   c = PC_LOW;
      2'b01:   c = PC_HIGH;
      default: c = PC_MID;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/gdrv_classify.sv
module gdrv_classify
  import gdrv_pkg::*;
#(
  parameter int HOLD_CYC  = 10,
  parameter int MINON_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] raw,
  output pwm_cls_e   cls,
  output logic       level_hi,
  output logic       mid_expired,
  output logic       high_qual
);

  localparam int RUN_MAX = ((HOLD_CYC > MINON_CYC) ? HOLD_CYC : MINON_CYC) + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_MAX);
  localparam logic [RUN_W-1:0] HOLD_V  = RUN_W'(HOLD_CYC);
  localparam logic [RUN_W-1:0] MINON_V = RUN_W'(MINON_CYC);

  pwm_cls_e         cls_in;
  pwm_cls_e         cls_q, cls_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             run_en;
  logic             lvl_q, lvl_d;
  logic             changed;

  always_comb begin
    cls_in  = decode_cls(raw);
    changed = (cls_in != cls_q);
    cls_d   = cls_in;
    run_en  = changed || (run_q != RUN_TOP);
    run_d   = changed ? RUN_W'(1) : (run_q + 1'b1);
    lvl_d   = (cls_q != PC_MID) ? (cls_q == PC_HIGH) : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q <= PC_LOW;
      run_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cls_q <= cls_d;
      lvl_q <= lvl_d;
      if (run_en) run_q <= run_d;
    end
  end

  assign cls         = cls_q;
  assign mid_expired = (cls_q == PC_MID) && (run_q > HOLD_V);
  assign high_qual   = (cls_q == PC_HIGH) && (run_q >= MINON_V);
  assign level_hi    = (cls_q == PC_HIGH) ? 1'b1 :
                       (cls_q == PC_LOW)  ? 1'b0 : lvl_q;

endmodule

// File: rtl/gdrv_deadtime.sv
module gdrv_deadtime #(
  parameter int DEAD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic hs_req,
  input  logic ls_req,
  input  logic hs_off_fb,
  input  logic ls_off_fb,
  output logic hs_gate,
  output logic ls_gate
);

  localparam int CNT_W = $clog2(DEAD_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DEAD_CYC - 1);

  logic             hs_q, hs_d;
  logic             ls_q, ls_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;
  logic             off_evt;
  logic             cnt_en;

  always_comb begin
    cnt_zero = (cnt_q == '0);
    hs_d = hs_req && !ls_req && !kill &&
           (hs_q || (!ls_q && ls_off_fb && cnt_zero));
    ls_d = ls_req && !hs_req && !kill &&
           (ls_q || (!hs_q && hs_off_fb && cnt_zero));
    off_evt = (hs_q && !hs_d) || (ls_q && !ls_d);
    cnt_en  = off_evt || !cnt_zero;
    cnt_d   = off_evt ? LOAD : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign hs_gate = hs_q;
  assign ls_gate = ls_q;

endmodule

// File: rtl/gdrv_seq.sv
module gdrv_seq
  import gdrv_pkg::*;
#(
  parameter int HOLD_CYC  = 10,
  parameter int MINON_CYC = 4,
  parameter int DEAD_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       en,
  input  logic [1:0] pwm_cls,
  input  logic       hs_off_fb,
  input  logic       ls_off_fb,
  output logic       hs_gate,
  output logic       ls_gate,
  output logic [2:0] mode
);

  logic [1:0] cls_sync;
  pwm_cls_e   cls;
  logic       level_hi, mid_expired, high_qual;
  logic       kill, drive_ok, hs_req, ls_req;
  mode_e      mode_q, mode_d;

  gdrv_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pwm_cls),
    .q     (cls_sync)
  );

  gdrv_classify #(.HOLD_CYC(HOLD_CYC), .MINON_CYC(MINON_CYC)) u_cls (
    .clk         (clk),
    .rst_n       (rst_n),
    .raw         (cls_sync),
    .cls         (cls),
    .level_hi    (level_hi),
    .mid_expired (mid_expired),
    .high_qual   (high_qual)
  );

  // mode sequencing: supply first, then enable, then the run modes
  always_comb begin
    kill = !supply_ok || !en;
    if (!supply_ok)   mode_d = MD_LOCKOUT;
    else if (!en)     mode_d = MD_DISABLED;
    else begin
      case (mode_q)
        MD_LOCKOUT, MD_DISABLED: mode_d = MD_PREBIAS;
        MD_PREBIAS: mode_d = high_qual   ? MD_SWITCH : MD_PREBIAS;
        MD_SWITCH:  mode_d = mid_expired ? MD_TRIOFF : MD_SWITCH;
        MD_TRIOFF:  mode_d = (cls != PC_MID) ? MD_SWITCH : MD_TRIOFF;
        default:    mode_d = MD_LOCKOUT;
      endcase
    end
    drive_ok = !kill &&
               (((mode_q == MD_SWITCH) && !mid_expired) ||
                ((mode_q == MD_TRIOFF) && (cls != PC_MID)));
    hs_req = drive_ok && level_hi;
    ls_req = drive_ok && !level_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MD_LOCKOUT;
    else        mode_q <= mode_d;
  end

  gdrv_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
    .clk       (clk),
    .rst_n     (rst_n),
    .kill      (kill),
    .hs_req    (hs_req),
    .ls_req    (ls_req),
    .hs_off_fb (hs_off_fb),
    .ls_off_fb (ls_off_fb),
    .hs_gate   (hs_gate),
    .ls_gate   (ls_gate)
  );

  assign mode = mode_q;

endmodule

// File: rtl/gdrv_seq_chk.sv
module gdrv_seq_chk
  import gdrv_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       en,
  input logic       hs_off_fb,
  input logic       ls_off_fb,
  input logic       hs_gate,
  input logic       ls_gate,
  input logic [2:0] mode
);

  localparam int GAP_W = $clog2(DEAD_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_TOP = GAP_W'(DEAD_CYC);

  // consecutive cycles with both gates low, saturating at the dead time
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap_q <= GAP_TOP;
    else if (hs_gate || ls_gate) gap_q <= '0;
    else if (gap_q != GAP_TOP)  gap_q <= gap_q + 1'b1;
  end

  a_r1_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_gate && !ls_gate));

  a_r2_lockout_off: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!hs_gate && !ls_gate && mode == 3'(MD_LOCKOUT)));

  a_r4_trioff_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'(MD_TRIOFF)) |-> (!hs_gate && !ls_gate));

  a_r5_prebias_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'(MD_PREBIAS)) |-> (!hs_gate && !ls_gate));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  a_r9_hs_needs_fb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> $past(ls_off_fb));

  a_r9_ls_needs_fb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> $past(hs_off_fb));

  a_r10_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_gate) || $rose(ls_gate)) |-> (gap_q >= GAP_TOP));

  a_r11_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd4);

endmodule

bind gdrv_seq gdrv_seq_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .supply_ok (supply_ok),
  .en        (en),
  .hs_off_fb (hs_off_fb),
  .ls_off_fb (ls_off_fb),
  .hs_gate   (hs_gate),
  .ls_gate   (ls_gate),
  .mode      (mode)
);

// File: tb/gdrv_seq_test.sv
`timescale 1ns/1ps
module gdrv_seq_test;

  localparam int HOLD  = 10;
  localparam int MINON = 4;
  localparam int DEAD  = 2;

  localparam logic [1:0] C_LOW  = 2'b00;
  localparam logic [1:0] C_HIGH = 2'b01;
  localparam logic [1:0] C_MID  = 2'b10;
  localparam logic [1:0] C_MID3 = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_ok, en;
  logic [1:0] pwm_cls;
  logic       hs_hold, ls_hold;
  logic       hs_gate, ls_gate;
  logic [2:0] mode;
  logic       hs_off_fb, ls_off_fb;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  // switch feedback: off when the gate is low, unless the bench holds it "on"
  assign hs_off_fb = !hs_gate && !hs_hold;
  assign ls_off_fb = !ls_gate && !ls_hold;

  gdrv_seq #(.HOLD_CYC(HOLD), .MINON_CYC(MINON), .DEAD_CYC(DEAD)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .en        (en),
    .pwm_cls   (pwm_cls),
    .hs_off_fb (hs_off_fb),
    .ls_off_fb (ls_off_fb),
    .hs_gate   (hs_gate),
    .ls_gate   (ls_gate),
    .mode      (mode)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // advance n rising edges (n >= 1), then stop at the following falling edge
  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; supply_ok = 1'b0; en = 1'b0; pwm_cls = C_LOW;
    hs_hold = 1'b0; ls_hold = 1'b0;
    edges(3);
    check("R11 reset mode", mode, 0);
    check("R2 reset gates", {hs_gate, ls_gate}, 0);
    rst_n = 1'b1;
    edges(2);
    check("R2 lockout after reset", mode, 0);
  endtask

  task automatic t_lockout_priority;
    en = 1'b1;
    edges(2);
    check("R2 lockout over enable", mode, 0);
    supply_ok = 1'b1;
    edges(1);
    check("R5 prebias entered", mode, 2);
  endtask

  task automatic t_prebias_hold;
    edges(20);
    check("R5 low pwm gates off", {hs_gate, ls_gate}, 0);
    check("R5 mode prebias", mode, 2);
  endtask

  task automatic t_short_guard_pulse;
    pwm_cls = C_HIGH;
    edges(MINON - 1);
    pwm_cls = C_LOW;
    edges(12);
    check("R6 short pulse keeps guard", mode, 2);
    check("R6 short pulse gates off", {hs_gate, ls_gate}, 0);
  endtask

  task automatic t_release;
    pwm_cls = C_HIGH;
    edges(MINON);
    pwm_cls = C_LOW;
    edges(2);
    check("R6 release not early", mode, 2);
    edges(1);
    check("R6 release mode", mode, 3);
    check("R6 ls not yet", ls_gate, 0);
    edges(1);
    check("R6 ls on after release", ls_gate, 1);
  endtask

  task automatic t_switch_edges;
    pwm_cls = C_HIGH;
    edges(3);
    check("R3 ls still on at edge 3", ls_gate, 1);
    edges(1);
    check("R3 ls off at edge 4", ls_gate, 0);
    edges(DEAD - 1);
    check("R10 both low in dead time", {hs_gate, ls_gate}, 0);
    edges(1);
    check("R3 hs on after dead time", hs_gate, 1);
    pwm_cls = C_LOW;
    edges(4);
    check("R3 hs off at edge 4", hs_gate, 0);
    edges(DEAD - 1);
    check("R10 both low before ls", {hs_gate, ls_gate}, 0);
    edges(1);
    check("R3 ls on after dead time", ls_gate, 1);
  endtask

  task automatic t_short_mid;
    int drops;
    drops = 0;
    pwm_cls = C_MID;
    for (int i = 0; i < HOLD; i++) begin
      edges(1);
      if (ls_gate !== 1'b1) drops++;
    end
    pwm_cls = C_LOW;
    for (int i = 0; i < 6; i++) begin
      edges(1);
      if (ls_gate !== 1'b1) drops++;
    end
    check("R4 short mid holds state", drops, 0);
    check("R4 short mid mode", mode, 3);
  endtask

  task automatic t_mid_timeout;
    pwm_cls = C_MID3;
    edges(3 + HOLD);
    check("R4 ls held at hold-off", ls_gate, 1);
    edges(1);
    check("R4 ls off after hold-off", ls_gate, 0);
    check("R11 tri-state mode", mode, 4);
    pwm_cls = C_HIGH;
    edges(3);
    check("R4 hs not yet", hs_gate, 0);
    edges(1);
    check("R4 hs on leaving tri-state", hs_gate, 1);
    check("R4 mode back to switching", mode, 3);
  endtask

  task automatic t_interlock;
    hs_hold = 1'b1;
    pwm_cls = C_LOW;
    edges(4);
    check("R9 hs commanded off", hs_gate, 0);
    edges(12);
    check("R9 ls waits for hs feedback", ls_gate, 0);
    hs_hold = 1'b0;
    edges(1);
    check("R9 ls on after feedback", ls_gate, 1);
    check("R8 not both on", {hs_gate, ls_gate}, 1);
  endtask

  task automatic t_short_in_switching;
    pwm_cls = C_HIGH;
    edges(MINON - 1);
    pwm_cls = C_LOW;
    edges(3);
    check("R7 short pulse switches hs", hs_gate, 1);
    check("R7 mode stays switching", mode, 3);
    edges(12);
    check("R7 back to ls", ls_gate, 1);
  endtask

  task automatic t_disable_rearm;
    en = 1'b0;
    pwm_cls = C_HIGH;
    edges(1);
    check("R1 gates off on disable", {hs_gate, ls_gate}, 0);
    check("R1 mode disabled", mode, 1);
    edges(10);
    check("R1 pwm high ignored", {hs_gate, ls_gate}, 0);
    pwm_cls = C_LOW;
    edges(5);
    en = 1'b1;
    edges(1);
    check("R7 rearm on enable", mode, 2);
    edges(10);
    check("R7 guard holds after rearm", {hs_gate, ls_gate}, 0);
    pwm_cls = C_HIGH;
    edges(MINON);
    pwm_cls = C_LOW;
    edges(4);
    check("R6 second release ls on", ls_gate, 1);
  endtask

  task automatic t_lockout_rearm;
    supply_ok = 1'b0;
    edges(1);
    check("R2 gates off on lockout", {hs_gate, ls_gate}, 0);
    check("R2 mode lockout", mode, 0);
    supply_ok = 1'b1;
    edges(1);
    check("R7 rearm after lockout", mode, 2);
    edges(8);
    check("R7 gates off after lockout", {hs_gate, ls_gate}, 0);
  endtask

  initial begin
    t_reset();
    t_lockout_priority();
    t_prebias_hold();
    t_short_guard_pulse();
    t_release();
    t_switch_edges();
    t_short_mid();
    t_mid_timeout();
    t_interlock();
    t_short_in_switching();
    t_disable_rearm();
    t_lockout_rearm();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule